// File: doc/BRIEF.md
# Hold-Off Sync Controller

This block is the timing gate for one channel of a tuner. It sits between the register interface and the oscillator datapath. New frequency and phase-offset words are written into shadow registers. They reach the active copies that drive the datapath only when a synchronization sequence completes. There are three sequences: channel start, frequency hop and phase update. Each one has its own hold-off count and its own choice of one of four external sync pins.

A sequence is armed by a rising edge on its selected pin or by the soft sync input, which arms all three sequences at once. Arming loads the hold-off count, and the counter then counts down on the master clock. When the count expires, the sequence raises a one-cycle done pulse. For the hop and phase sequences, the active register takes the shadow value on that same edge. Several channels or chips that share the sync pins can therefore switch on the same clock.

Top module: `holdoff_sync_ctrl`

## Requirements
- R1: While `rstN` is low and on the first cycle after it is released, all done outputs are 0, `activeFreq` and `activePhase` are 0, and every readable register reads 0.
- R2: Register map. Addresses 0, 1 and 2 hold the start, hop and phase hold-off words, with the count in bits 15:0 and the pin selector in bits 17:16. These read back masked to 18 bits. Address 3 holds the 32-bit frequency shadow, and address 4 holds the phase shadow in bits 15:0. All other addresses read 0. `regRdData` reflects `regAddr` combinationally, and a write takes effect at the clock edge where `regWrEn` is high.
- R3: The active registers cannot be read through `regRdData`. Writing a shadow register leaves `activeFreq` and `activePhase` unchanged until the matching sequence completes.
- R4: Suppose `softSync` is high at clock edge k and the hold-off count of a sequence is N. That sequence's done output then goes high just after edge k+N. A count of 0 means the done output goes high just after edge k itself.
- R5: A sequence reacts only to the pin that its selector names (value 0 to 3 picks `syncPins[0]` to `syncPins[3]`). That pin passes through two synchronizing flops and an edge detector. A rising edge present before edge a is treated as an event at edge a+2. Edges on other pins and falling edges have no effect.
- R6: An event that arrives while a countdown is running restarts it from the programmed count. The done output then follows N edges after the new event, and no pulse comes from the abandoned countdown.
- R7: `activeFreq` loads the frequency shadow on the edge at which `hopDone` rises, and changes at no other time.
- R8: `activePhase` loads the phase shadow on the edge at which `phaseDone` rises, and changes at no other time.
- R9: Each done output is a one-cycle pulse when no further event arrives. The start sequence produces only its pulse and moves no register.
- R10: The three sequences are independent. Each uses its own count and selector, so one soft sync can complete them on different cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all counters run on it |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and readback |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Readback of the addressed register |
| syncPins | input | 4 | Asynchronous external sync pins |
| softSync | input | 1 | Synchronous software sync, arms all three sequences |
| startDone | output | 1 | Channel start pulse |
| hopDone | output | 1 | Frequency transfer pulse |
| phaseDone | output | 1 | Phase transfer pulse |
| activeFreq | output | 32 | Active frequency word to the oscillator |
| activePhase | output | 16 | Active phase offset to the oscillator |

## Verification
The state in this block that can go wrong is the counter value, the busy flag and the synchronizer flops, and each fault shows up at the ports within one hold-off period. A counter that loads or decrements wrongly moves a done pulse off its expected edge. A lost busy flag removes the pulse entirely. A stale synchronizer stage shifts pin-driven events by a cycle. A wrong shadow-to-active path shows up as `activeFreq` or `activePhase` taking a wrong value on the pulse edge, or changing away from it. So the bench counts the edges from each event to each done pulse, and compares the active words on that edge.

// File: rtl/sync_ctrl_pkg.sv
package sync_ctrl_pkg;
  localparam int CNT_W    = 16;
  localparam int SEL_W    = 2;
  localparam int NUM_PINS = 1 << SEL_W;
  localparam int NUM_SEQ  = 3;
  localparam int CFG_W    = CNT_W + SEL_W;

  typedef enum logic [1:0] {
    SEQ_START = 2'd0,
    SEQ_HOP   = 2'd1,
    SEQ_PHASE = 2'd2
  } seqId_e;

  // pinSel lands in bits 17:16 of the register word, count in 15:0
  typedef struct packed {
    logic [SEL_W-1:0] pinSel;
    logic [CNT_W-1:0] count;
  } holdCfg_t;

  typedef struct packed {
    logic xferFreq;
    logic xferPhase;
  } xferStrobe_t;
endpackage

// File: rtl/holdoff_counter.sv
module holdoff_counter
  import sync_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinRise,
  input  logic                softSync,
  input  holdCfg_t            cfg,
  output logic                fire,
  output logic                done
);
  logic [CNT_W-1:0] cntQ;
  logic             busyQ;
  logic             seqEvent;
  logic             lastCount;

  assign seqEvent  = softSync | pinRise[cfg.pinSel];
  assign lastCount = busyQ && (cntQ == CNT_W'(1));

  // an event wins over an expiring countdown: restart semantics
  always_comb begin
    if (seqEvent) fire = (cfg.count == '0);
    else          fire = lastCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      busyQ <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= fire;
      if (seqEvent) begin
        cntQ  <= cfg.count;
        busyQ <= (cfg.count != '0);
      end else if (busyQ) begin
        if (lastCount) busyQ <= 1'b0;
        else           cntQ  <= cntQ - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sync_seq_ctrl.sv
module sync_seq_ctrl
  import sync_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] syncPins,
  input  logic                softSync,
  input  holdCfg_t            holdCfg [NUM_SEQ],
  output xferStrobe_t         strobe,
  output logic [NUM_SEQ-1:0]  seqDone
);
  logic [NUM_PINS-1:0] meta1Q, meta2Q, prevQ;
  logic [NUM_PINS-1:0] pinRise;
  logic [NUM_SEQ-1:0]  seqFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta1Q <= '0;
      meta2Q <= '0;
      prevQ  <= '0;
    end else begin
      meta1Q <= syncPins;
      meta2Q <= meta1Q;
      prevQ  <= meta2Q;
    end
  end

  assign pinRise = meta2Q & ~prevQ;

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
    holdoff_counter u_cnt (
      .clk      (clk),
      .rstN     (rstN),
      .pinRise  (pinRise),
      .softSync (softSync),
      .cfg      (holdCfg[g]),
      .fire     (seqFire[g]),
      .done     (seqDone[g])
    );
  end

  assign strobe.xferFreq  = seqFire[SEQ_HOP];
  assign strobe.xferPhase = seqFire[SEQ_PHASE];
endmodule

// File: rtl/sync_cfg_regs.sv
module sync_cfg_regs
  import sync_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  xferStrobe_t        strobe,
  output logic [DATA_W-1:0]  rdData,
  output holdCfg_t           holdCfg [NUM_SEQ],
  output logic [FREQ_W-1:0]  shadowFreq,
  output logic [PHASE_W-1:0] shadowPhase,
  output logic [FREQ_W-1:0]  activeFreq,
  output logic [PHASE_W-1:0] activePhase
);
  localparam logic [ADDR_W-1:0] ADDR_FREQ  = ADDR_W'(NUM_SEQ);
  localparam logic [ADDR_W-1:0] ADDR_PHASE = ADDR_W'(NUM_SEQ + 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEQ; i++) holdCfg[i] <= '0;
      shadowFreq  <= '0;
      shadowPhase <= '0;
    end else if (wrEn) begin
      for (int i = 0; i < NUM_SEQ; i++)
        if (addr == ADDR_W'(i)) holdCfg[i] <= holdCfg_t'(wrData[CFG_W-1:0]);
      if (addr == ADDR_FREQ)  shadowFreq  <= wrData[FREQ_W-1:0];
      if (addr == ADDR_PHASE) shadowPhase <= wrData[PHASE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeFreq  <= '0;
      activePhase <= '0;
    end else begin
      if (strobe.xferFreq)  activeFreq  <= shadowFreq;
      if (strobe.xferPhase) activePhase <= shadowPhase;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_SEQ; i++)
      if (addr == ADDR_W'(i)) rdData = {{(DATA_W-CFG_W){1'b0}}, holdCfg[i]};
    if (addr == ADDR_FREQ)  rdData = DATA_W'(shadowFreq);
    if (addr == ADDR_PHASE) rdData = DATA_W'(shadowPhase);
  end
endmodule

// File: rtl/holdoff_sync_ctrl.sv
module holdoff_sync_ctrl
  import sync_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_PINS-1:0] syncPins,
  input  logic               softSync,
  output logic               startDone,
  output logic               hopDone,
  output logic               phaseDone,
  output logic [FREQ_W-1:0]  activeFreq,
  output logic [PHASE_W-1:0] activePhase
);
  holdCfg_t             holdCfg [NUM_SEQ];
  xferStrobe_t          strobe;
  logic [NUM_SEQ-1:0]   seqDone;
  logic [FREQ_W-1:0]    shadowFreq;
  logic [PHASE_W-1:0]   shadowPhase;

  sync_cfg_regs #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .FREQ_W (FREQ_W), .PHASE_W (PHASE_W)
  ) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (regWrEn),
    .addr        (regAddr),
    .wrData      (regWrData),
    .strobe      (strobe),
    .rdData      (regRdData),
    .holdCfg     (holdCfg),
    .shadowFreq  (shadowFreq),
    .shadowPhase (shadowPhase),
    .activeFreq  (activeFreq),
    .activePhase (activePhase)
  );

  sync_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .syncPins (syncPins),
    .softSync (softSync),
    .holdCfg  (holdCfg),
    .strobe   (strobe),
    .seqDone  (seqDone)
  );

  assign startDone = seqDone[SEQ_START];
  assign hopDone   = seqDone[SEQ_HOP];
  assign phaseDone = seqDone[SEQ_PHASE];
endmodule

// File: rtl/sync_ctrl_checker.sv
module sync_ctrl_checker
  import sync_ctrl_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               softSync,
  input logic               hopDone,
  input logic               phaseDone,
  input logic [CNT_W-1:0]   hopCount,
  input logic [CNT_W-1:0]   phaseCount,
  input logic [FREQ_W-1:0]  shadowFreq,
  input logic [PHASE_W-1:0] shadowPhase,
  input logic [FREQ_W-1:0]  activeFreq,
  input logic [PHASE_W-1:0] activePhase
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  p_freq_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !hopDone) |-> $stable(activeFreq));

  p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !phaseDone) |-> $stable(activePhase));

  p_freq_xfer_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && hopDone) |-> (activeFreq == $past(shadowFreq)));

  p_phase_xfer_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && phaseDone) |-> (activePhase == $past(shadowPhase)));

  p_zero_hop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (softSync && hopCount == '0) |=> hopDone);

  p_zero_phase_r4: assert property (@(posedge clk) disable iff (!rstN)
    (softSync && phaseCount == '0) |=> phaseDone);
endmodule

bind holdoff_sync_ctrl sync_ctrl_checker #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .softSync    (softSync),
  .hopDone     (hopDone),
  .phaseDone   (phaseDone),
  .hopCount    (holdCfg[1].count),
  .phaseCount  (holdCfg[2].count),
  .shadowFreq  (shadowFreq),
  .shadowPhase (shadowPhase),
  .activeFreq  (activeFreq),
  .activePhase (activePhase)
);

// File: tb/sim_holdoff_sync_ctrl.sv
`timescale 1ns/1ps
module sim_holdoff_sync_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  syncPins = '0;
  logic        softSync = 1'b0;
  logic        startDone, hopDone, phaseDone;
  logic [31:0] activeFreq;
  logic [15:0] activePhase;

  int checks = 0;
  int errors = 0;

  int          cfgN [3];
  int          cfgSel [3];
  logic [31:0] expShFreq = '0, expActFreq = '0;
  logic [15:0] expShPhase = '0, expActPhase = '0;

  always #5 clk = ~clk;

  holdoff_sync_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .syncPins(syncPins),
    .softSync(softSync), .startDone(startDone), .hopDone(hopDone),
    .phaseDone(phaseDone), .activeFreq(activeFreq), .activePhase(activePhase)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [2:0] doneVec();
    return {phaseDone, hopDone, startDone};
  endfunction

  // edges from the event-driving tick to the done pulse; 0 = never
  function automatic int expTicks(input bit usePin, input int sel, input int pin, input int n);
    if (!usePin) return n + 1;
    if (sel == pin) return n + 3;
    return 0;
  endfunction

  task automatic setCfg(input int s, input int n, input int sel);
    cfgN[s] = n; cfgSel[s] = sel;
    regWrite(3'(s), {14'd0, 2'(sel), 16'(n)});
  endtask

  // fire one event, watch all three done outputs
  task automatic runEvent(input bit usePin, input int pin, input string tag);
    int got [3];
    int width [3];
    int lim;
    lim = 0;
    for (int s = 0; s < 3; s++) begin
      got[s] = 0; width[s] = 0;
      if (cfgN[s] + 6 > lim) lim = cfgN[s] + 6;
    end
    if (usePin) syncPins[pin] = 1'b1; else softSync = 1'b1;
    for (int i = 1; i <= lim; i++) begin
      tick();
      softSync = 1'b0;
      for (int s = 0; s < 3; s++) begin
        if (doneVec()[s]) begin
          if (got[s] == 0) got[s] = i;
          width[s]++;
        end
        if (doneVec()[1]) expActFreq = expShFreq;
        if (doneVec()[2]) expActPhase = expShPhase;
      end
      if (hopDone) check(activeFreq == expShFreq, "R7", activeFreq, expShFreq);
      if (phaseDone) check(activePhase == expShPhase, "R8", activePhase, expShPhase);
    end
    for (int s = 0; s < 3; s++) begin
      int e;
      e = expTicks(usePin, cfgSel[s], pin, cfgN[s]);
      check(got[s] == e, usePin ? "R5 R10 latency" : "R4 R10 latency", got[s], e);
      check(width[s] == (e == 0 ? 0 : 1), "R9 pulse width", width[s], (e == 0 ? 0 : 1));
    end
    check(activeFreq == expActFreq, "R7 final", activeFreq, expActFreq);
    check(activePhase == expActPhase, "R8 final", activePhase, expActPhase);
    if (usePin) begin
      syncPins[pin] = 1'b0;
      for (int i = 0; i < 4; i++) begin
        tick();
        check(doneVec() == 3'b0, "R5 falling edge", doneVec(), 0);
      end
    end
    if (tag.len() < 0) $display("%s", tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    for (int s = 0; s < 3; s++) begin cfgN[s] = 0; cfgSel[s] = 0; end

    // R1 reset state
    repeat (3) tick();
    check(doneVec() == 3'b0, "R1 done in reset", doneVec(), 0);
    check(activeFreq == 0 && activePhase == 0, "R1 active in reset", activeFreq, 0);
    rstN = 1'b1;
    tick();
    check(doneVec() == 3'b0, "R1 done after reset", doneVec(), 0);
    for (int a = 0; a < 8; a++) begin
      regRead(3'(a), rd);
      check(rd == 0, "R1 readback after reset", rd, 0);
    end

    // R2 register map and masking
    regWrite(3'd0, 32'hFFFF_FFFF);
    regRead(3'd0, rd);
    check(rd == 32'h0003_FFFF, "R2 holdoff mask", rd, 32'h0003_FFFF);
    regWrite(3'd4, 32'hABCD_1234); expShPhase = 16'h1234;
    regRead(3'd4, rd);
    check(rd == 32'h0000_1234, "R2 phase shadow", rd, 32'h1234);
    regWrite(3'd5, 32'h5555_5555);
    regRead(3'd5, rd);
    check(rd == 0, "R2 unused address", rd, 0);

    // R3 shadow write does not move active
    regWrite(3'd3, 32'hDEAD_BEEF); expShFreq = 32'hDEAD_BEEF;
    regRead(3'd3, rd);
    check(rd == 32'hDEAD_BEEF, "R2 freq shadow", rd, 32'hDEAD_BEEF);
    for (int i = 0; i < 3; i++) tick();
    check(activeFreq == 0, "R3 freq untouched", activeFreq, 0);
    check(activePhase == 0, "R3 phase untouched", activePhase, 0);

    // R4 zero and nonzero counts via soft sync, R9 start has no register effect
    setCfg(0, 0, 0); setCfg(1, 5, 1); setCfg(2, 1, 2);
    runEvent(1'b0, 0, "soft");

    // R5 pin selected only for start; hop and phase watch other pins
    setCfg(0, 2, 2); setCfg(1, 3, 1); setCfg(2, 0, 3);
    regWrite(3'd3, 32'h0102_0304); expShFreq = 32'h0102_0304;
    runEvent(1'b1, 2, "pin");

    // R6 restart: hop count 10, second soft sync at tick 5
    begin
      int first;
      setCfg(0, 0, 0); setCfg(1, 10, 0); setCfg(2, 0, 0);
      softSync = 1'b1;
      first = 0;
      for (int i = 1; i <= 20; i++) begin
        tick();
        softSync = (i == 4);
        if (hopDone && first == 0) first = i;
      end
      check(first == 15, "R6 restart latency", first, 15);
      expActFreq = expShFreq; expActPhase = expShPhase;
    end

    // long hold-off
    setCfg(0, 1000, 0); setCfg(1, 999, 0); setCfg(2, 3, 0);
    regWrite(3'd4, 32'h0000_7777); expShPhase = 16'h7777;
    runEvent(1'b0, 0, "long");

    // random mix
    for (int it = 0; it < 24; it++) begin
      bit usePin;
      for (int s = 0; s < 3; s++) setCfg(s, int'($urandom_range(0, 15)), int'($urandom_range(0, 3)));
      expShFreq = $urandom;
      regWrite(3'd3, expShFreq);
      expShPhase = 16'($urandom);
      regWrite(3'd4, {16'd0, expShPhase});
      check(activeFreq == expActFreq, "R3 random shadow write", activeFreq, expActFreq);
      usePin = ($urandom_range(0, 1) == 1);
      runEvent(usePin, int'($urandom_range(0, 3)), "rand");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule